// File: doc/BRIEF.md
# Delayed Read Completion Tracker

This block sits behind the target side of a PCI-style bridge and handles one delayed read. The first inbound memory read that finds the tracker empty is told to retry. Its address and byte enables are captured, and a fetch request goes upstream. When the upstream data arrives, the captured entry becomes a valid completion and a discard timer starts. The master repeats its read. If that request carries the same address and byte enables, it receives the data and the entry is freed. If the timer runs out first, the completion is thrown away, every captured field returns to zero, and an error pulse is raised if software has enabled it.

The three memory read flavours are treated as interchangeable when a repeat is compared with the entry. I/O reads and all other commands are never claimed. The bus protocol engine and the upstream fetch path are outside the block. Each is reduced to a plain valid/ready or valid-only handshake.

The controller has four states:
- `ST_IDLE`: the tracker is empty.
- `ST_ISSUE`: the upstream request is being offered.
- `ST_WAIT`: the tracker is waiting for upstream data.
- `ST_VALID`: the completion is held and the timer runs.

The state changes as follows:
- `ST_IDLE` to `ST_ISSUE` on a memory read.
- `ST_ISSUE` to `ST_WAIT` when `up_req_ready` is high.
- `ST_WAIT` to `ST_VALID` when `up_rsp_valid` is high.
- `ST_VALID` to `ST_IDLE` when a matching read is served.
- `ST_VALID` to `ST_IDLE` when the timer expires without a match.

Top module: `drc_tracker`

## Requirements
- R1: After reset `resp_code` is 2'b00, `resp_data` is zero, `up_req_valid` is low and `err_discard` is low.
- R2: The response to a request sampled at a clock edge appears on `resp_code` after that edge. The codes are 2'b00 (not claimed), 2'b01 (retry) and 2'b10 (data). An I/O read (`req_cmd` 4'b0010) and every command other than the three memory reads are answered with 2'b00 and leave the tracker unchanged.
- R3: The memory read commands are 4'b0110, 4'b1100 and 4'b1110. A memory read that finds the tracker empty is answered with retry and its address and byte enables are captured. `up_req_valid` then rises and stays high, with `up_req_addr`/`up_req_be` stable, until `up_req_ready` is sampled high.
- R4: While the fetch is outstanding (request offered or data awaited), every memory read is answered with retry, including one that matches, and the captured fields stay unchanged.
- R5: A memory read in the valid state whose address and byte enables both equal the captured ones is answered with data 2'b10 and the fetched word on `resp_data`, whichever of the three read codes it uses. The entry is then freed, so the next read starts a new fetch.
- R6: In the valid state, a memory read that differs in address or in byte enables is answered with retry and does not disturb the held completion.
- R7: The completion can be claimed by requests sampled on the 2^TMR_W clock edges that follow the edge accepting the upstream data, the last of those edges included.
- R8: If no match arrives within that window, the completion is discarded and the captured fields are cleared. The next memory read is answered with retry and starts a new fetch.
- R9: On a discard, `err_discard` pulses high for exactly one cycle when `cfg_err_en` is 1, and stays low when it is 0.
- R10: `up_rsp_valid` is ignored in every state other than waiting for data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_err_en | input | 1 | Report discards on `err_discard` |
| req_valid | input | 1 | Inbound request present this cycle |
| req_cmd | input | 4 | Inbound bus command |
| req_addr | input | AW | Inbound address |
| req_be | input | BEW | Inbound byte enables |
| resp_code | output | 2 | Registered response: 00 none, 01 retry, 10 data |
| resp_data | output | DW | Read data, valid with response 10 |
| up_req_valid | output | 1 | Upstream fetch request |
| up_req_ready | input | 1 | Upstream accepts the fetch |
| up_req_addr | output | AW | Fetch address |
| up_req_be | output | BEW | Fetch byte enables |
| up_rsp_valid | input | 1 | Upstream read data present |
| up_rsp_data | input | DW | Upstream read data |
| err_discard | output | 1 | One-cycle pulse on an unclaimed discard |

## Verification
The bench builds the tracker with TMR_W = 4, which shortens the discard window to 16 clocks. This makes the last claimable edge and the first expired edge cheap to reach, with the error enable both on and off. AW, DW and BEW keep their 32/32/4 defaults, so the address and byte-enable mismatch cases use realistic field widths.

// File: rtl/drc_pkg.sv
package drc_pkg;

    typedef enum logic [1:0] {
        RSP_NONE  = 2'b00,
        RSP_RETRY = 2'b01,
        RSP_DATA  = 2'b10
    } rsp_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_ISSUE = 2'b01,
        ST_WAIT  = 2'b10,
        ST_VALID = 2'b11
    } drc_state_e;

    localparam logic [3:0] CMD_MEM_RD      = 4'b0110;
    localparam logic [3:0] CMD_MEM_RD_MULT = 4'b1100;
    localparam logic [3:0] CMD_MEM_RD_LINE = 4'b1110;

    function automatic logic is_mem_read(input logic [3:0] cmd);
        return (cmd == CMD_MEM_RD) || (cmd == CMD_MEM_RD_MULT) ||
               (cmd == CMD_MEM_RD_LINE);
    endfunction

endpackage

// File: rtl/drc_match.sv
module drc_match #(
    parameter int AW  = 32,
    parameter int BEW = 4
) (
    input  logic [3:0]     cmd,
    input  logic [AW-1:0]  addr,
    input  logic [BEW-1:0] be,
    input  logic [AW-1:0]  ent_addr,
    input  logic [BEW-1:0] ent_be,
    output logic           rd_class,
    output logic           fields_eq
);
    import drc_pkg::*;

    // Read flavour is deliberately not compared: any memory read qualifies.
    assign rd_class  = is_mem_read(cmd);
    assign fields_eq = (addr == ent_addr) && (be == ent_be);

endmodule

// File: rtl/drc_timer.sv
module drc_timer #(
    parameter int TMR_W = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    logic [TMR_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (!run) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end

    assign expire = run && (cnt_q == {TMR_W{1'b1}});

    AST_TMR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (!run) |=> (cnt_q == '0)); // R7

endmodule

// File: rtl/drc_tracker.sv
module drc_tracker #(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int BEW   = 4,
    parameter int TMR_W = 15
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_err_en,
    input  logic           req_valid,
    input  logic [3:0]     req_cmd,
    input  logic [AW-1:0]  req_addr,
    input  logic [BEW-1:0] req_be,
    output logic [1:0]     resp_code,
    output logic [DW-1:0]  resp_data,
    output logic           up_req_valid,
    input  logic           up_req_ready,
    output logic [AW-1:0]  up_req_addr,
    output logic [BEW-1:0] up_req_be,
    input  logic           up_rsp_valid,
    input  logic [DW-1:0]  up_rsp_data,
    output logic           err_discard
);
    import drc_pkg::*;

    drc_state_e     state_q, state_d;
    logic [AW-1:0]  ent_addr_q;
    logic [BEW-1:0] ent_be_q;
    logic [DW-1:0]  ent_data_q;
    logic           rd_class, fields_eq, expire;
    logic           mem_rd, hit, discard;
    rsp_e           resp_q;

    drc_match #(.AW(AW), .BEW(BEW)) u_match (
        .cmd      (req_cmd),
        .addr     (req_addr),
        .be       (req_be),
        .ent_addr (ent_addr_q),
        .ent_be   (ent_be_q),
        .rd_class (rd_class),
        .fields_eq(fields_eq)
    );

    drc_timer #(.TMR_W(TMR_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q == ST_VALID),
        .expire(expire)
    );

    assign mem_rd  = req_valid && rd_class;
    assign hit     = mem_rd && fields_eq && (state_q == ST_VALID);
    // A match in the final window cycle wins over the discard.
    assign discard = expire && !hit;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (mem_rd)          state_d = ST_ISSUE;
            ST_ISSUE: if (up_req_ready)    state_d = ST_WAIT;
            ST_WAIT:  if (up_rsp_valid)    state_d = ST_VALID;
            ST_VALID: if (hit || discard)  state_d = ST_IDLE;
            default:                       state_d = ST_IDLE;
        endcase
    end

    // State and entry registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            ent_addr_q <= '0;
            ent_be_q   <= '0;
            ent_data_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && mem_rd) begin
                ent_addr_q <= req_addr;
                ent_be_q   <= req_be;
            end
            if (state_q == ST_WAIT && up_rsp_valid)
                ent_data_q <= up_rsp_data;
            if (state_q == ST_VALID && (hit || discard)) begin
                ent_addr_q <= '0;
                ent_be_q   <= '0;
                ent_data_q <= '0;
            end
        end
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_q      <= RSP_NONE;
            resp_data   <= '0;
            err_discard <= 1'b0;
        end else begin
            err_discard <= discard && cfg_err_en;
            resp_data   <= '0;
            if (!mem_rd) begin
                resp_q <= RSP_NONE;
            end else if (hit) begin
                resp_q    <= RSP_DATA;
                resp_data <= ent_data_q;
            end else begin
                resp_q <= RSP_RETRY;
            end
        end
    end

    assign resp_code    = resp_q;
    assign up_req_valid = (state_q == ST_ISSUE);
    assign up_req_addr  = ent_addr_q;
    assign up_req_be    = ent_be_q;

    AST_UNCLAIMED_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid || !is_mem_read(req_cmd)) |=> (resp_code == RSP_NONE)); // R2
    AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (up_req_valid && !up_req_ready) |=>
        (up_req_valid && $stable(up_req_addr) && $stable(up_req_be))); // R3
    AST_PENDING_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_ISSUE || state_q == ST_WAIT) && mem_rd) |=>
        (resp_code == RSP_RETRY)); // R4
    AST_DATA_FROM_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_code == RSP_DATA) |-> ($past(state_q) == ST_VALID && state_q == ST_IDLE)); // R5
    AST_DISCARD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        err_discard |-> (state_q == ST_IDLE && ent_addr_q == '0 && ent_be_q == '0)); // R8
    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        err_discard |=> !err_discard); // R9
    AST_RSP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (up_rsp_valid && state_q != ST_WAIT) |=> $stable(ent_data_q)); // R10

endmodule

// File: tb/drc_tracker_tb.sv
`timescale 1ns/1ps
module drc_tracker_tb;
    localparam int AW = 32, DW = 32, BEW = 4, TMR_W = 4;
    localparam int LIMIT = 2 ** TMR_W;
    localparam logic [1:0] NONE = 2'b00, RETRY = 2'b01, DATA = 2'b10;
    localparam logic [3:0] MR = 4'b0110, MRM = 4'b1100, MRL = 4'b1110;
    localparam logic [3:0] IORD = 4'b0010, MWR = 4'b0111;

    logic clk = 1'b0, rst_n = 1'b0, cfg_err_en = 1'b0;
    logic req_valid = 1'b0, up_req_ready = 1'b0, up_rsp_valid = 1'b0;
    logic [3:0] req_cmd = '0;
    logic [AW-1:0] req_addr = '0;
    logic [BEW-1:0] req_be = '0;
    logic [DW-1:0] up_rsp_data = '0;
    logic [1:0] resp_code;
    logic [DW-1:0] resp_data;
    logic up_req_valid, err_discard;
    logic [AW-1:0] up_req_addr;
    logic [BEW-1:0] up_req_be;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    drc_tracker #(.AW(AW), .DW(DW), .BEW(BEW), .TMR_W(TMR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_err_en(cfg_err_en),
        .req_valid(req_valid), .req_cmd(req_cmd), .req_addr(req_addr), .req_be(req_be),
        .resp_code(resp_code), .resp_data(resp_data),
        .up_req_valid(up_req_valid), .up_req_ready(up_req_ready),
        .up_req_addr(up_req_addr), .up_req_be(up_req_be),
        .up_rsp_valid(up_rsp_valid), .up_rsp_data(up_rsp_data),
        .err_discard(err_discard));

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send(input logic [3:0] c, input logic [AW-1:0] a, input logic [BEW-1:0] b);
        @(negedge clk);
        req_valid = 1'b1; req_cmd = c; req_addr = a; req_be = b;
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic pulse_ready();
        @(negedge clk); up_req_ready = 1'b1;
        @(posedge clk); #1; up_req_ready = 1'b0;
    endtask

    task automatic pulse_rsp(input logic [DW-1:0] d);
        @(negedge clk); up_rsp_valid = 1'b1; up_rsp_data = d;
        @(posedge clk); #1; up_rsp_valid = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 resp_code", resp_code, NONE);
        check("R1 resp_data", resp_data, '0);
        check("R1 up_req_valid", up_req_valid, 0);
        check("R1 err_discard", err_discard, 0);
    endtask

    task automatic t_unclaimed();
        send(IORD, 32'h1000, 4'hF);
        check("R2 io read resp", resp_code, NONE);
        check("R2 io read no fetch", up_req_valid, 0);
        send(MWR, 32'h1000, 4'hF);
        check("R2 write resp", resp_code, NONE);
        pulse_rsp(32'hBAD0BAD0);           // R10 in idle
        send(MR, 32'h2000, 4'h3);
        check("R10 idle rsp ignored", resp_code, RETRY);
        check("R3 fetch raised", up_req_valid, 1);
        pulse_ready(); pulse_rsp(32'h11);
        send(MR, 32'h2000, 4'h3);
        check("R5 claim cleanup", resp_code, DATA);
    endtask

    task automatic t_main_flow();
        send(MR, 32'hA000_0040, 4'hF);
        check("R3 first read retry", resp_code, RETRY);
        check("R3 fetch valid", up_req_valid, 1);
        check("R3 fetch addr", up_req_addr, 32'hA000_0040);
        check("R3 fetch be", up_req_be, 4'hF);
        idle(3);
        check("R3 fetch held", up_req_valid, 1);
        check("R3 addr held", up_req_addr, 32'hA000_0040);
        pulse_rsp(32'hDEAD0000);           // R10 while issuing
        send(MR, 32'hA000_0040, 4'hF);
        check("R4 issue-state retry", resp_code, RETRY);
        pulse_ready();
        check("R3 fetch dropped after ready", up_req_valid, 0);
        send(MRL, 32'hA000_0040, 4'hF);
        check("R4 wait-state retry", resp_code, RETRY);
        send(MR, 32'hB000_0000, 4'h1);
        check("R4 mismatch no disturb", up_req_addr, 32'hA000_0040);
        pulse_rsp(32'hCAFE_F00D);
        send(MR, 32'hA000_0044, 4'hF);
        check("R6 addr mismatch retry", resp_code, RETRY);
        send(MR, 32'hA000_0040, 4'h7);
        check("R6 be mismatch retry", resp_code, RETRY);
        send(MRM, 32'hA000_0040, 4'hF);
        check("R5 data code", resp_code, DATA);
        check("R5 data word", resp_data, 32'hCAFE_F00D);
        check("R10 stale rsp not kept", resp_data == 32'hDEAD0000, 0);
        send(MR, 32'hA000_0040, 4'hF);
        check("R5 freed then retry", resp_code, RETRY);
        check("R5 new fetch", up_req_valid, 1);
        pulse_ready(); pulse_rsp(32'h22);
        send(MR, 32'hA000_0040, 4'hF);
        check("R5 second claim", resp_data, 32'h22);
    endtask

    task automatic t_last_edge();
        send(MRL, 32'h0000_3000, 4'hC);
        pulse_ready(); pulse_rsp(32'h3333_4444);
        idle(LIMIT - 1);
        send(MR, 32'h0000_3000, 4'hC);
        check("R7 last edge served", resp_code, DATA);
        check("R7 last edge data", resp_data, 32'h3333_4444);
        idle(1);
        check("R7 no discard error", err_discard, 0);
    endtask

    task automatic t_expire(input logic en);
        @(negedge clk); cfg_err_en = en;
        send(MR, 32'h0000_5000, 4'h5);
        pulse_ready(); pulse_rsp(32'h5555);
        idle(LIMIT);
        check(en ? "R9 err pulse high" : "R9 err stays low", err_discard, en);
        check("R8 fetch addr cleared", up_req_addr, '0);
        idle(1);
        check("R9 err one cycle", err_discard, 0);
        send(MR, 32'h0000_5000, 4'h5);
        check("R8 expired gives retry", resp_code, RETRY);
        check("R8 new fetch", up_req_valid, 1);
        pulse_ready(); pulse_rsp(32'h6666);
        send(MR, 32'h0000_5000, 4'h5);
        check("R8 refetched data", resp_data, 32'h6666);
    endtask

    initial begin
        #40000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_unclaimed();
        t_main_flow();
        t_last_edge();
        t_expire(1'b1);
        t_expire(1'b0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule